// File: doc/BRIEF.md
# Two-Lane Registered Bus Transceiver

This block sits between two 16-bit buses, an A side and a B side, and stores data passing in either direction. The width is split into two independent byte lanes. Each lane owns two storage registers, one for traffic moving from A to B and one for traffic moving from B to A. Each of the four lane-direction pairs has its own capture clock, an active-low capture enable and an active-low drive enable, so a lane can load and present data in one direction without disturbing the other.

Every bus line has a keeper. Whenever a line is actively driven, by the block or by an outside agent, the keeper follows it; once nothing drives the line, the line keeps its last driven level instead of floating. Each bus side is modelled as a split pin set: an external drive value with a per-lane drive request coming in, and the resolved line level going out. Connecting the matching controls of both lanes turns the block into one 16-bit registered transceiver.

Top module: `bus_xcvr_reg`

## Requirements
- R1: Lane k covers bits 8k+7 down to 8k of both buses, and lane 0 uses index 0 of every per-lane control vector; two lanes give 16 bits per side.
- R2: On a rising edge of a lane's A-to-B clock with that lane's A-to-B capture enable low, the A-to-B register loads the lane's current A line level.
- R3: With the A-to-B capture enable high, a rising A-to-B clock edge leaves the A-to-B register unchanged.
- R4: With the A-to-B drive enable low, the lane's B lines show the A-to-B register; with it high, the block releases the B lines, and an external B driver, when present, sets them.
- R5: The B-to-A path mirrors R2 to R4 with its own clock, capture enable and drive enable, loading from the B lines and driving the A lines.
- R6: While a drive enable stays low and no qualifying capture occurs, the driven lines keep showing the previously stored value.
- R7: A line that neither the block nor an external driver drives shows the last level actively driven onto it.
- R8: The two registers of a lane are separate storage: loading one direction never alters the other direction's contents.
- R9: The lanes are independent: capturing in one lane leaves the other lane's registers unchanged, and equal controls on both lanes give full 16-bit operation.
- R10: A rising clock edge with reset high clears the register it clocks, and reset high clears every keeper, so lines read zero after reset until driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Reset, active high: synchronous for registers, level for keepers |
| clk_ab | input | 2 | Per-lane A-to-B capture clock |
| clk_ba | input | 2 | Per-lane B-to-A capture clock |
| ce_ab_n | input | 2 | Per-lane A-to-B capture enable, active low |
| ce_ba_n | input | 2 | Per-lane B-to-A capture enable, active low |
| oe_ab_n | input | 2 | Per-lane B-side drive enable, active low |
| oe_ba_n | input | 2 | Per-lane A-side drive enable, active low |
| a_ext | input | 16 | Value an outside agent places on the A bus |
| a_ext_en | input | 2 | Per-lane request that the outside agent drives the A bus |
| b_ext | input | 16 | Value an outside agent places on the B bus |
| b_ext_en | input | 2 | Per-lane request that the outside agent drives the B bus |
| a_line | output | 16 | Resolved A bus level |
| b_line | output | 16 | Resolved B bus level |

## Verification
A register result is due right after the rising edge of its own lane clock, with no further delay, and a line change caused by a drive enable or by an external driver is immediate, because the lines and keepers are combinational paths around the registers. The bench therefore changes controls first, gives a capture clock a complete high-then-low pulse, and samples the lines one time unit after the last change, never at an edge. Keeper results are checked by releasing every driver of a lane and reading the line in the same settled interval, before any new stimulus reaches it.

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  localparam int W     = LANE_W * LANES
) (
  input  logic             rst,
  input  logic [LANES-1:0] clk_ab,
  input  logic [LANES-1:0] clk_ba,
  input  logic [LANES-1:0] ce_ab_n,
  input  logic [LANES-1:0] ce_ba_n,
  input  logic [LANES-1:0] oe_ab_n,
  input  logic [LANES-1:0] oe_ba_n,
  input  logic [W-1:0]     a_ext,
  input  logic [LANES-1:0] a_ext_en,
  input  logic [W-1:0]     b_ext,
  input  logic [LANES-1:0] b_ext_en,
  output logic [W-1:0]     a_line,
  output logic [W-1:0]     b_line
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] ab_q, ba_q;
    logic [LANE_W-1:0] a_keep, b_keep;
    logic [LANE_W-1:0] a_src, b_src;
    logic              a_act, b_act;

    // who is driving each side of this lane
    assign a_act = !oe_ba_n[g] || a_ext_en[g];
    assign b_act = !oe_ab_n[g] || b_ext_en[g];
    assign a_src = !oe_ba_n[g] ? ba_q : a_ext[g*LANE_W +: LANE_W];
    assign b_src = !oe_ab_n[g] ? ab_q : b_ext[g*LANE_W +: LANE_W];

    // bus keepers follow the line while it is driven
    always_latch begin
      if (rst)        a_keep = '0;
      else if (a_act) a_keep = a_src;
    end

    always_latch begin
      if (rst)        b_keep = '0;
      else if (b_act) b_keep = b_src;
    end

    assign a_line[g*LANE_W +: LANE_W] = a_act ? a_src : a_keep;
    assign b_line[g*LANE_W +: LANE_W] = b_act ? b_src : b_keep;

    always_ff @(posedge clk_ab[g]) begin
      if (rst)              ab_q <= '0;
      else if (!ce_ab_n[g]) ab_q <= a_line[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk_ba[g]) begin
      if (rst)              ba_q <= '0;
      else if (!ce_ba_n[g]) ba_q <= b_line[g*LANE_W +: LANE_W];
    end

    AST_AB_CAPTURE: assert property (@(posedge clk_ab[g]) disable iff (rst)
      !ce_ab_n[g] |=> ab_q == $past(a_line[g*LANE_W +: LANE_W])); // R2
    AST_AB_HOLD: assert property (@(posedge clk_ab[g]) disable iff (rst)
      ce_ab_n[g] |=> $stable(ab_q)); // R3
    AST_BA_CAPTURE: assert property (@(posedge clk_ba[g]) disable iff (rst)
      !ce_ba_n[g] |=> ba_q == $past(b_line[g*LANE_W +: LANE_W])); // R5
    AST_B_STEADY: assert property (@(posedge clk_ab[g]) disable iff (rst)
      (!oe_ab_n[g] && $past(!oe_ab_n[g]) && $past(ce_ab_n[g]))
        |-> $stable(b_line[g*LANE_W +: LANE_W])); // R6

    always_comb begin
      if (!rst) begin
        AST_NO_FIGHT_A: assert (!(a_ext_en[g] && !oe_ba_n[g])); // R4
        AST_NO_FIGHT_B: assert (!(b_ext_en[g] && !oe_ab_n[g])); // R4
      end
    end
  end

endmodule

// File: tb/sim_bus_xcvr_reg.sv
module sim_bus_xcvr_reg;
  logic        clk = 0;
  logic        rst;
  logic [1:0]  clk_ab, clk_ba, ce_ab_n, ce_ba_n, oe_ab_n, oe_ba_n;
  logic [15:0] a_ext, b_ext;
  logic [1:0]  a_ext_en, b_ext_en;
  logic [15:0] a_line, b_line;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [15:0] exp_ab, exp_ba;

  bus_xcvr_reg u0 (
    .rst(rst), .clk_ab(clk_ab), .clk_ba(clk_ba),
    .ce_ab_n(ce_ab_n), .ce_ba_n(ce_ba_n),
    .oe_ab_n(oe_ab_n), .oe_ba_n(oe_ba_n),
    .a_ext(a_ext), .a_ext_en(a_ext_en),
    .b_ext(b_ext), .b_ext_en(b_ext_en),
    .a_line(a_line), .b_line(b_line)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [1:0] ab, input logic [1:0] ba);
    #2; clk_ab = ab; clk_ba = ba;
    #2; clk_ab = 2'b00; clk_ba = 2'b00;
    #1;
  endtask

  initial begin
    rst = 1; clk_ab = 0; clk_ba = 0;
    ce_ab_n = 2'b11; ce_ba_n = 2'b11; oe_ab_n = 2'b11; oe_ba_n = 2'b11;
    a_ext = 16'hFFFF; b_ext = 16'hFFFF; a_ext_en = 0; b_ext_en = 0;
    exp_ab = 0; exp_ba = 0;
    pulse(2'b11, 2'b11);
    pulse(2'b11, 2'b11);
    rst = 0; #1;
    chk("R10 a keeper", a_line, 16'h0000);
    chk("R10 b keeper", b_line, 16'h0000);
    oe_ab_n = 2'b00; oe_ba_n = 2'b00; #1;
    chk("R10 ab reg", b_line, 16'h0000);
    chk("R10 ba reg", a_line, 16'h0000);
    oe_ab_n = 2'b11; oe_ba_n = 2'b11; #1;

    // R1 R2 R4 R7: full-width sweep, both lanes tied
    for (int v = 0; v < 256; v += 5) begin
      a_ext = {8'(v) ^ 8'hA5, 8'(v)}; a_ext_en = 2'b11; ce_ab_n = 2'b00;
      pulse(2'b11, 2'b00);
      exp_ab = {8'(v) ^ 8'hA5, 8'(v)};
      ce_ab_n = 2'b11; a_ext_en = 2'b00; #1;
      chk("R7 a keeper after release", a_line, exp_ab);
      oe_ab_n = 2'b00; #1;
      chk("R2 R4 R1 b driven", b_line, exp_ab);
      oe_ab_n = 2'b11; #1;
      chk("R7 b keeper after release", b_line, exp_ab);
    end

    // R3: capture enable high blocks loading
    a_ext = 16'h1234; a_ext_en = 2'b11; ce_ab_n = 2'b11;
    pulse(2'b11, 2'b00);
    a_ext_en = 0; oe_ab_n = 2'b00; #1;
    chk("R3 ce high holds", b_line, exp_ab);

    // R6: repeated edges without capture keep output steady
    pulse(2'b11, 2'b11); pulse(2'b11, 2'b00);
    chk("R6 steady output", b_line, exp_ab);
    oe_ab_n = 2'b11; #1;

    // R9: only lane 0 captures
    a_ext = 16'hC3E7; a_ext_en = 2'b11; ce_ab_n = 2'b10;
    pulse(2'b11, 2'b00);
    exp_ab = {exp_ab[15:8], 8'hE7};
    ce_ab_n = 2'b11; a_ext_en = 0; oe_ab_n = 2'b00; #1;
    chk("R9 lane independence", b_line, exp_ab);
    oe_ab_n = 2'b11; #1;

    // R5 R8: B-to-A load, A-to-B unaffected
    for (int v = 0; v < 256; v += 51) begin
      b_ext = {8'(v), ~8'(v)}; b_ext_en = 2'b11; ce_ba_n = 2'b00;
      pulse(2'b00, 2'b11);
      exp_ba = {8'(v), ~8'(v)};
      ce_ba_n = 2'b11; b_ext_en = 0; oe_ba_n = 2'b00; oe_ab_n = 2'b00; #1;
      chk("R5 a driven from ba", a_line, exp_ba);
      chk("R8 ab unchanged", b_line, exp_ab);
      oe_ba_n = 2'b11; oe_ab_n = 2'b11; #1;
      chk("R7 a keeper", a_line, exp_ba);
    end

    // R4: released B side follows external driver
    oe_ab_n = 2'b11; b_ext = 16'h5A0F; b_ext_en = 2'b11; #1;
    chk("R4 released b external", b_line, 16'h5A0F);
    b_ext_en = 0; #1;
    chk("R7 b keeps external level", b_line, 16'h5A0F);

    // R9: lane 1 B-to-A only
    b_ext = 16'h9911; b_ext_en = 2'b11; ce_ba_n = 2'b01;
    pulse(2'b00, 2'b10);
    exp_ba = {8'h99, exp_ba[7:0]};
    ce_ba_n = 2'b11; b_ext_en = 0; oe_ba_n = 2'b00; #1;
    chk("R9 lane1 only ba", a_line, exp_ba);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule